// File: doc/BRIEF.md
# Sampled Shadow-Tag Miss Profiler

This block measures, for one application and over one profiling interval, how many misses that application would see at three candidate partition sizes. It also counts the misses the application actually takes in its real partition. The block receives only the accesses that fall in sampled sets, which is a small fixed fraction of the cache's sets. Each access carries a short hashed tag instead of the full address tag. Three shadow tag directories process every sampled access in parallel. The first is as associative as the smallest partition the application may get. The second is as associative as the largest. The third has an associativity that the allocation logic may change at each interval boundary, so that it can probe a chosen point of the miss curve.

All three directories use true least-recently-used replacement, kept as a small age counter per way. The variable directory looks up and replaces only in its first K ways, where K is its configured size. Writeback requests update the directories in the same way as any other access, but they never add to a miss count. On the interval-end strobe the four running counts are captured into the output registers and the running counters restart. An access that arrives in the strobe cycle counts toward the new interval. The counters stop at all ones and do not wrap.

Top module: `shadow_miss_profiler`

## Requirements
- R1: After reset all four count outputs read zero and every shadow directory is empty.
- R2: The minimum directory holds MIN_WAYS tags per sampled set with true LRU replacement. A non-writeback access that misses in it adds one to the minimum count.
- R3: The maximum directory holds MAX_WAYS tags per sampled set with true LRU replacement. A non-writeback access that misses in it adds one to the maximum count.
- R4: The variable directory looks up and replaces only within its first K ways and counts non-writeback misses in the variable count. K is loaded from `var_size_i` on the interval-end strobe, with 0 treated as 1 and any value above MAX_WAYS treated as MAX_WAYS. The new K already applies to an access in the strobe cycle.
- R5: When a strobe changes K, the variable directory is emptied before the access of that cycle is looked up. When a strobe leaves K unchanged, the directory keeps its contents.
- R6: An access with `acc_wb_i`=1 updates the directories' tags and LRU order but adds to no count. A real miss with `rm_wb_i`=1 adds nothing to the real count.
- R7: Each cycle with `rm_valid_i`=1 and `rm_wb_i`=0 adds one to the real count, whatever the shadow directories report.
- R8: On a cycle with `interval_end_i`=1, each output takes the count of the interval that is ending. Each counter restarts at zero plus any increment from that same cycle.
- R9: The outputs change only on the cycle after an interval-end strobe.
- R10: A counter that reaches 2^CNT_W-1 stays there until the next strobe.
- R11: Sets are independent. Accesses to one sampled set never evict or reorder the entries of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Sampled access present this cycle |
| acc_set_i | input | SET_W | Index of the sampled set |
| acc_tag_i | input | TAG_W | Hashed tag of the access |
| acc_wb_i | input | 1 | Access is a writeback request |
| rm_valid_i | input | 1 | Miss in the application's real partition |
| rm_wb_i | input | 1 | That real miss came from a writeback |
| interval_end_i | input | 1 | Interval-end strobe |
| var_size_i | input | KW | Ways for the variable directory in the next interval |
| cnt_min_o | output | CNT_W | Captured miss count, minimum size |
| cnt_max_o | output | CNT_W | Captured miss count, maximum size |
| cnt_var_o | output | CNT_W | Captured miss count, variable size |
| cnt_real_o | output | CNT_W | Captured miss count, real partition |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- A strobe that changes the variable size must empty the variable directory. A design that kept stale tags would report a hit where a cold miss belongs.
- A strobe with the size unchanged must keep the directory. A design that emptied it every time would count spurious misses.
- Writeback fills must change LRU state without being counted. A design that counted them would inflate every count; a design that skipped the fill would miss on the read that follows.
- An access in the strobe cycle must land in the new interval. An off-by-one design would move it into the captured value.
- Other directed cases cover size values 0 and above the maximum, counter saturation and set isolation, which catch designs that wrap, that misclamp, or that decode the set index wrongly.

// File: rtl/shadow_miss_profiler.sv
module shadow_miss_profiler #(
  parameter int SETS     = 16,
  parameter int MIN_WAYS = 2,
  parameter int MAX_WAYS = 8,
  parameter int TAG_W    = 10,
  parameter int CNT_W    = 24,
  parameter int SIZE_RST = 4,
  localparam int SET_W   = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int AGE_W   = $clog2(MAX_WAYS),
  localparam int KW      = $clog2(MAX_WAYS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid_i,
  input  logic [SET_W-1:0] acc_set_i,
  input  logic [TAG_W-1:0] acc_tag_i,
  input  logic             acc_wb_i,
  input  logic             rm_valid_i,
  input  logic             rm_wb_i,
  input  logic             interval_end_i,
  input  logic [KW-1:0]    var_size_i,
  output logic [CNT_W-1:0] cnt_min_o,
  output logic [CNT_W-1:0] cnt_max_o,
  output logic [CNT_W-1:0] cnt_var_o,
  output logic [CNT_W-1:0] cnt_real_o
);

  function automatic logic [KW-1:0] clamp_k(input logic [KW-1:0] s);
    if (s == '0) return KW'(1);
    if (int'(s) > MAX_WAYS) return KW'(MAX_WAYS);
    return s;
  endfunction

  logic [KW-1:0] k_q, k_new, k_eff;
  logic          resize;

  assign k_new  = clamp_k(var_size_i);
  assign resize = interval_end_i && (k_new != k_q);
  assign k_eff  = interval_end_i ? k_new : k_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              k_q <= clamp_k(KW'(SIZE_RST));
    else if (interval_end_i) k_q <= k_new;

  logic [2:0] miss;

  for (genvar d = 0; d < 3; d++) begin : g_dir
    localparam int NW = (d == 0) ? MIN_WAYS : MAX_WAYS;

    logic [TAG_W-1:0] tag_q [SETS][NW];
    logic [AGE_W-1:0] age_q [SETS][NW];
    logic [NW-1:0]    vld_q [SETS];

    logic [KW-1:0]    kk;
    logic             flush;
    logic [NW-1:0]    v_row, v_nxt;
    logic [AGE_W-1:0] a_row [NW];
    logic [AGE_W-1:0] a_nxt [NW];
    logic             hit, free_f;
    int               hw, fw, vw, tgt;

    assign kk    = (d == 0) ? KW'(MIN_WAYS) : (d == 1) ? KW'(MAX_WAYS) : k_eff;
    assign flush = (d == 2) && resize;

    always_comb begin
      v_row  = flush ? '0 : vld_q[acc_set_i];
      hit    = 1'b0;
      free_f = 1'b0;
      hw = 0; fw = 0; vw = 0;
      for (int w = 0; w < NW; w++) begin
        a_row[w] = age_q[acc_set_i][w];
        if (w < int'(kk)) begin
          if (v_row[w] && tag_q[acc_set_i][w] == acc_tag_i && !hit) begin
            hit = 1'b1;
            hw  = w;
          end
          if (!v_row[w] && !free_f) begin
            free_f = 1'b1;
            fw     = w;
          end
          if (v_row[w] && a_row[w] == AGE_W'(kk - 1'b1)) vw = w;
        end
      end
      tgt = hit ? hw : (free_f ? fw : vw);
      for (int w = 0; w < NW; w++) begin
        a_nxt[w] = a_row[w];
        if (w == tgt)
          a_nxt[w] = '0;
        else if (w < int'(kk) && v_row[w] && (!hit || a_row[w] < a_row[hw]))
          a_nxt[w] = a_row[w] + 1'b1;
      end
      v_nxt = v_row;
      v_nxt[tgt] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else begin
        if (flush)
          for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        if (acc_valid_i) vld_q[acc_set_i] <= v_nxt;
      end

    always_ff @(posedge clk)
      if (acc_valid_i)
        for (int w = 0; w < NW; w++) begin
          age_q[acc_set_i][w] <= a_nxt[w];
          if (w == tgt) tag_q[acc_set_i][w] <= acc_tag_i;
        end

    assign miss[d] = acc_valid_i && !hit;
  end

  logic [3:0]            inc;
  logic [3:0][CNT_W-1:0] cnt_q, cnt_d, out_q;

  assign inc = {rm_valid_i && !rm_wb_i, miss & {3{!acc_wb_i}}};

  for (genvar i = 0; i < 4; i++) begin : g_cnt
    logic [CNT_W-1:0] base;
    assign base     = interval_end_i ? '0 : cnt_q[i];
    assign cnt_d[i] = (&base) ? base : base + CNT_W'(inc[i]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (interval_end_i) out_q <= cnt_q;
    end

  assign cnt_min_o  = out_q[0];
  assign cnt_max_o  = out_q[1];
  assign cnt_var_o  = out_q[2];
  assign cnt_real_o = out_q[3];

endmodule

// File: rtl/profiler_chk.sv
module profiler_chk #(
  parameter int CNT_W = 24
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  interval_end_i,
  input logic                  acc_valid_i,
  input logic                  acc_wb_i,
  input logic                  rm_valid_i,
  input logic                  rm_wb_i,
  input logic [3:0][CNT_W-1:0] cnt_q,
  input logic [3:0][CNT_W-1:0] out_q
);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !interval_end_i |=> $stable(out_q));

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    interval_end_i |=> out_q == $past(cnt_q));

  p_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!interval_end_i && (&cnt_q[3])) |=> (&cnt_q[3]));

  p_wb_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!interval_end_i && (!acc_valid_i || acc_wb_i) && !(rm_valid_i && !rm_wb_i))
      |=> $stable(cnt_q));

  p_inclusion_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[1] <= cnt_q[0]);

  p_var_vs_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[1] <= cnt_q[2]);

endmodule

bind shadow_miss_profiler profiler_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .interval_end_i(interval_end_i),
  .acc_valid_i(acc_valid_i), .acc_wb_i(acc_wb_i),
  .rm_valid_i(rm_valid_i), .rm_wb_i(rm_wb_i),
  .cnt_q(cnt_q), .out_q(out_q)
);

// File: tb/shadow_miss_profiler_tb.sv
module shadow_miss_profiler_tb;
  localparam int SETS = 4, MINW = 1, MAXW = 4, TAGW = 10, CW = 8, SRST = 4;
  localparam int SW = 2, KW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_wb = 0, rm_valid = 0, rm_wb = 0, iend = 0;
  logic [SW-1:0] acc_set = '0;
  logic [TAGW-1:0] acc_tag = '0;
  logic [KW-1:0] vsize = '0;
  logic [CW-1:0] o_min, o_max, o_var, o_real;

  always #2 clk = ~clk;

  shadow_miss_profiler #(.SETS(SETS), .MIN_WAYS(MINW), .MAX_WAYS(MAXW), .TAG_W(TAGW),
    .CNT_W(CW), .SIZE_RST(SRST)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid), .acc_set_i(acc_set),
    .acc_tag_i(acc_tag), .acc_wb_i(acc_wb), .rm_valid_i(rm_valid), .rm_wb_i(rm_wb),
    .interval_end_i(iend), .var_size_i(vsize), .cnt_min_o(o_min), .cnt_max_o(o_max),
    .cnt_var_o(o_var), .cnt_real_o(o_real));

  int errors = 0, checks = 0;
  bit done = 0;

  bit          m_v  [3][SETS][MAXW];
  logic [9:0]  m_t  [3][SETS][MAXW];
  int          m_st [3][SETS][MAXW];
  int          now = 0, mk;
  int          m_cnt [4];
  int          e_out [4];

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic int clampk(int s);
    if (s == 0) return 1;
    if (s > MAXW) return MAXW;
    return s;
  endfunction

  function automatic bit m_access(int d, int s, logic [9:0] t, int k);
    int hw = -1, fw = -1, vw = 0, oldest = 32'h7fffffff;
    now++;
    for (int w = 0; w < k; w++)
      if (m_v[d][s][w] && m_t[d][s][w] == t && hw < 0) hw = w;
    if (hw >= 0) begin
      m_st[d][s][hw] = now;
      return 1'b0;
    end
    for (int w = 0; w < k; w++)
      if (!m_v[d][s][w] && fw < 0) fw = w;
    if (fw >= 0) vw = fw;
    else
      for (int w = 0; w < k; w++)
        if (m_st[d][s][w] < oldest) begin
          oldest = m_st[d][s][w];
          vw = w;
        end
    m_v[d][s][vw] = 1'b1;
    m_t[d][s][vw] = t;
    m_st[d][s][vw] = now;
    return 1'b1;
  endfunction

  function automatic void bump(int i);
    if (m_cnt[i] < (1 << CW) - 1) m_cnt[i]++;
  endfunction

  task automatic step(bit v, int s, int t, bit wb, bit rv, bit rwb, bit e, int sz);
    int ks[3];
    @(negedge clk);
    check("R2 R9 min count", int'(o_min), e_out[0]);
    check("R3 R9 max count", int'(o_max), e_out[1]);
    check("R4 R9 var count", int'(o_var), e_out[2]);
    check("R7 R9 real count", int'(o_real), e_out[3]);
    acc_valid = v; acc_set = SW'(s); acc_tag = TAGW'(t); acc_wb = wb;
    rm_valid = rv; rm_wb = rwb; iend = e; vsize = KW'(sz);
    if (e) begin
      for (int i = 0; i < 4; i++) begin
        e_out[i] = m_cnt[i];
        m_cnt[i] = 0;
      end
      if (clampk(sz) != mk) begin
        mk = clampk(sz);
        for (int a = 0; a < SETS; a++)
          for (int w = 0; w < MAXW; w++) m_v[2][a][w] = 1'b0;
      end
    end
    ks[0] = MINW; ks[1] = MAXW; ks[2] = mk;
    if (v)
      for (int d = 0; d < 3; d++)
        if (m_access(d, s, 10'(t), ks[d]) && !wb) bump(d);
    if (rv && !rwb) bump(3);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic strobe(int sz);
    step(0, 0, 0, 0, 0, 0, 1, sz);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    for (int d = 0; d < 3; d++)
      for (int a = 0; a < SETS; a++)
        for (int w = 0; w < MAXW; w++) begin
          m_v[d][a][w] = 0; m_st[d][a][w] = 0; m_t[d][a][w] = '0;
        end
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; e_out[i] = 0; end
    mk = clampk(SRST);
    seed_dummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset min", int'(o_min), 0);
    check("R1 reset max", int'(o_max), 0);
    check("R1 reset var", int'(o_var), 0);
    check("R1 reset real", int'(o_real), 0);

    // R2 R3: A,B,A in set 0 -> 1-way misses 3, 4-way misses 2
    step(1, 0, 1, 0, 0, 0, 0, 0);
    step(1, 0, 2, 0, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0, 0);
    strobe(4); idle();
    check("R2 directed min", int'(o_min), 3);
    check("R3 directed max", int'(o_max), 2);
    check("R4 directed var", int'(o_var), 2);

    // R6: writeback fill is not counted but makes the next read hit
    step(1, 1, 5, 1, 1, 1, 0, 0);
    step(1, 1, 5, 0, 0, 0, 0, 0);
    strobe(4); idle();
    check("R6 wb min", int'(o_min), 0);
    check("R6 wb max", int'(o_max), 0);
    check("R6 wb real", int'(o_real), 0);

    // R5: resize empties, same size keeps
    strobe(2);
    step(1, 2, 7, 0, 0, 0, 0, 0);
    strobe(2);
    step(1, 2, 7, 0, 0, 0, 0, 0);
    strobe(2); idle();
    check("R5 keep var", int'(o_var), 0);
    strobe(3);
    step(1, 2, 7, 0, 0, 0, 0, 0);
    strobe(3); idle();
    check("R5 flush var", int'(o_var), 1);
    check("R5 flush max", int'(o_max), 0);

    // R10: saturation of the real counter
    for (int n = 0; n < 300; n++) step(0, 0, 0, 0, 1, 0, 0, 0);
    strobe(3); idle();
    check("R10 saturate real", int'(o_real), 255);

    // R8: access in the strobe cycle belongs to the new interval
    step(1, 3, 9, 0, 1, 0, 1, 3);
    strobe(3); idle();
    check("R8 strobe access min", int'(o_min), 1);
    check("R8 strobe access var", int'(o_var), 1);
    check("R8 strobe real", int'(o_real), 1);

    // R11: set 0 still holds tag 1 in the 1-way directory
    step(1, 0, 1, 0, 0, 0, 0, 0);
    strobe(3); idle();
    check("R11 set isolation min", int'(o_min), 0);

    // R4: size 0 clamps to 1, size 7 clamps to MAXW
    strobe(0);
    step(1, 0, 3, 0, 0, 0, 0, 0);
    step(1, 0, 4, 0, 0, 0, 0, 0);
    step(1, 0, 3, 0, 0, 0, 0, 0);
    strobe(7); idle();
    check("R4 clamp low var", int'(o_var), 3);

    for (int n = 0; n < 3000; n++)
      step(($urandom % 4) != 0, $urandom % SETS, $urandom % 6, ($urandom % 5) == 0,
           ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 40) == 0, $urandom % 8);
    strobe(2); idle(); idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule